// File: doc/BRIEF.md
# Two-step timestamp capture queue

This block holds hardware egress timestamps for two-step precision time protocol handling until software collects them. A transmit capture strobe carries the egress port, the nanoseconds value of the local time counter and the frame's identifier. In one cycle the block stores two entries: a transmit stamp entry, then an identifier entry whose stamp and sub-nanosecond fields together rebuild the frame identifier. A receive capture strobe stores a single entry with its transmit flag clear. The time counter and the frame datapath stay outside the block; only their strobes and sampled values arrive here.

Software sees the oldest entry through three registers. It reads the status/control register, then the stamp register, then the sub-nanosecond register, and it pops the entry by writing the self-clearing pop bit. A level interrupt stays high while entries wait and the enable bit is set. The capture inputs have no back-pressure, because a timestamp cannot be delayed. Each strobe is taken in the cycle it is high, or it is dropped and the sticky overflow flag records the loss.

Register map (32-bit data, 2-bit address). Address 0, status/control: bit 0 valid (read only), bit 1 overflow (write 1 to clear), bit 2 transmit flag (read only), bit 3 pop (write 1, always reads 0), bit 4 interrupt enable (read/write), bits 15:8 port. Address 1, stamp: bits 31:0. Address 2, sub-nanoseconds: bits 7:0. Address 3 reads 0.

Top module: `ts_capture_fifo`

## Requirements
- R1: A transmit strobe stores two entries in order. The first has the transmit flag set, the strobe's port and the nanoseconds value in the stamp field. The second has the transmit flag clear and the same port.
- R2: In the identifier entry, the stamp field holds the identifier shifted right by 8 and the sub-nanosecond field holds identifier bits 7:0. Stamp shifted left by 8, ORed with the sub-nanosecond field, gives back the identifier.
- R3: A receive strobe stores one entry with the transmit flag clear, the strobe's port, its nanoseconds value and a sub-nanosecond field of 0.
- R4: A read of address 0 returns valid in bit 0, overflow in bit 1, the head's transmit flag in bit 2, interrupt enable in bit 4 and the head's port in bits 15:8. Addresses 1 and 2 return the head's stamp and sub-nanosecond fields. Entries leave in the order they arrived.
- R5: Writing 1 to bit 3 of address 0 removes the head entry whatever its transmit flag, and the following entry becomes the head. Bit 3 always reads 0.
- R6: While the queue is empty, valid and the transmit flag read 0 and the port, stamp and sub-nanosecond fields read 0. A pop write has no effect.
- R7: A strobe that finds too little room is dropped and sets overflow. Overflow stays set until software writes 1 to bit 1 of address 0. A drop in the same cycle as that clear write leaves it set.
- R8: A transmit strobe that finds fewer than two free slots stores neither entry, so a pair is never split.
- R9: When transmit and receive strobes arrive in the same cycle, the transmit pair is handled and the receive entry is dropped with overflow set.
- R10: The interrupt output is high exactly while the queue holds an entry and interrupt enable is 1.
- R11: A receive push and a pop in the same cycle leave the occupancy unchanged. Free room is judged on the occupancy before that cycle's pop, so a full queue drops the push.
- R12: Read data appears on the clock edge after the address is presented. Reset empties the queue and clears overflow and interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt_i | input | 1 | Transmit capture strobe |
| tx_port_i | input | PORT_W | Egress port of the transmitted frame |
| tx_nsec_i | input | NSEC_W | Nanoseconds value at transmission |
| tx_id_i | input | ID_W | Identifier of the transmitted frame |
| rx_evt_i | input | 1 | Receive capture strobe |
| rx_port_i | input | PORT_W | Port of the received frame |
| rx_nsec_i | input | NSEC_W | Nanoseconds value at reception |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the address |
| irq_o | output | 1 | Level interrupt request |

## Verification
A table of transmit strobes is run through the queue. Its entries use extreme ports, stamps and identifiers, including all-zero and all-one values, so that a swapped pair order, a wrong shift or a dropped sub-nanosecond byte gives a different read-back. Directed sequences fill the queue to the exact slot count where a pair no longer fits. They then check that the receive entry that follows still fits, that the queue drains in arrival order, and that no part of a dropped pair appears. Coincident cases set a transmit strobe against a receive strobe, a drop against an overflow clear, and a push against a pop on both an occupancy of one and a full queue. These separate a correct judgment of free room from one that counts the cycle's pop.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  localparam int REG_W   = 32;
  localparam int SUBNS_W = 8;
  localparam int PORTF_W = 8;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAMP = 2'd1;
  localparam logic [1:0] ADDR_SUBNS = 2'd2;

  localparam int BIT_VALID = 0;
  localparam int BIT_OVF   = 1;
  localparam int BIT_TX    = 2;
  localparam int BIT_POP   = 3;
  localparam int BIT_IEN   = 4;
  localparam int PORT_LSB  = 8;

  typedef struct packed {
    logic                 is_tx;
    logic [PORTF_W-1:0]   port;
    logic [REG_W-1:0]     stamp;
    logic [SUBNS_W-1:0]   subns;
  } tsq_entry_t;

endpackage

// File: rtl/tsq_admit.sv
module tsq_admit
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 6,
  parameter int NSEC_W = 30,
  parameter int ID_W   = 24,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              tx_evt,
  input  logic [PORT_W-1:0] tx_port,
  input  logic [NSEC_W-1:0] tx_nsec,
  input  logic [ID_W-1:0]   tx_id,
  input  logic              rx_evt,
  input  logic [PORT_W-1:0] rx_port,
  input  logic [NSEC_W-1:0] rx_nsec,
  input  logic [CNT_W-1:0]  count,
  output logic [1:0]        push_n,
  output tsq_entry_t        wr0,
  output tsq_entry_t        wr1,
  output logic              drop
);

  localparam int FREE_W = CNT_W + 1;

  logic [FREE_W-1:0] free_slots;
  tsq_entry_t        tx_stamp_e, tx_id_e, rx_e;

  assign free_slots = FREE_W'(DEPTH) - {1'b0, count};

  always_comb begin
    tx_stamp_e       = '0;
    tx_stamp_e.is_tx = 1'b1;
    tx_stamp_e.port  = PORTF_W'(tx_port);
    tx_stamp_e.stamp = REG_W'(tx_nsec);

    tx_id_e          = '0;
    tx_id_e.port     = PORTF_W'(tx_port);
    tx_id_e.stamp    = REG_W'(tx_id >> SUBNS_W);
    tx_id_e.subns    = tx_id[SUBNS_W-1:0];

    rx_e             = '0;
    rx_e.port        = PORTF_W'(rx_port);
    rx_e.stamp       = REG_W'(rx_nsec);
  end

  always_comb begin
    push_n = 2'd0;
    wr0    = tx_stamp_e;
    wr1    = tx_id_e;
    drop   = 1'b0;
    if (tx_evt) begin
      if (free_slots >= FREE_W'(2)) push_n = 2'd2;
      else                          drop   = 1'b1;
      if (rx_evt)                   drop   = 1'b1;
    end else if (rx_evt) begin
      wr0 = rx_e;
      if (free_slots != '0) push_n = 2'd1;
      else                  drop   = 1'b1;
    end
  end

endmodule

// File: rtl/tsq_ring.sv
module tsq_ring
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       push_n,
  input  tsq_entry_t       wr0,
  input  tsq_entry_t       wr1,
  input  logic             pop,
  output tsq_entry_t       head,
  output logic [CNT_W-1:0] count
);

  tsq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_p1, wr_ptr_p2;
  logic [DEPTH-1:0] we_first, we_second;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ptr_p1 = step(wr_ptr);
  assign wr_ptr_p2 = step(wr_ptr_p1);
  assign pop_ok    = pop && (count != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot_we
    assign we_first[i]  = (push_n != 2'd0) && (wr_ptr == PTR_W'(i));
    assign we_second[i] = (push_n == 2'd2) && (wr_ptr_p1 == PTR_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_first[i])       mem[i] <= wr0;
      else if (we_second[i]) mem[i] <= wr1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      case (push_n)
        2'd1:    wr_ptr <= wr_ptr_p1;
        2'd2:    wr_ptr <= wr_ptr_p2;
        default: wr_ptr <= wr_ptr;
      endcase
      if (pop_ok) rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(push_n) - CNT_W'(pop_ok);
    end
  end

  assign head = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7

  AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R6

endmodule

// File: rtl/tsq_csr.sv
module tsq_csr
  import tsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  tsq_entry_t       head,
  input  logic             nonempty,
  input  logic             drop,
  output logic [REG_W-1:0] rdata,
  output logic             pop,
  output logic             irq
);

  logic             ovf_q, ien_q, ovf_clr, ctrl_wr;
  logic [REG_W-1:0] rdata_d;
  logic             unused_wdata;

  assign ctrl_wr = we && (addr == ADDR_CTRL);
  assign pop     = ctrl_wr && wdata[BIT_POP] && nonempty;
  assign ovf_clr = ctrl_wr && wdata[BIT_OVF];
  assign irq     = ien_q && nonempty;
  assign unused_wdata = ^{wdata[REG_W-1:BIT_IEN+1], wdata[BIT_TX], wdata[BIT_VALID]};

  always_comb begin
    rdata_d = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata_d[BIT_VALID] = nonempty;
        rdata_d[BIT_OVF]   = ovf_q;
        rdata_d[BIT_TX]    = nonempty && head.is_tx;
        rdata_d[BIT_IEN]   = ien_q;
        rdata_d[PORT_LSB +: PORTF_W] = nonempty ? head.port : '0;
      end
      ADDR_STAMP: rdata_d = nonempty ? head.stamp : '0;
      ADDR_SUBNS: rdata_d[SUBNS_W-1:0] = nonempty ? head.subns : '0;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ien_q <= 1'b0;
      rdata <= '0;
    end else begin
      ovf_q <= (ovf_q && !ovf_clr) || drop;
      if (ctrl_wr) ien_q <= wdata[BIT_IEN];
      rdata <= rdata_d;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q); // R7

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q); // R7

endmodule

// File: rtl/ts_capture_fifo.sv
module ts_capture_fifo
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 6,
  parameter int NSEC_W = 30,
  parameter int ID_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_evt_i,
  input  logic [PORT_W-1:0] tx_port_i,
  input  logic [NSEC_W-1:0] tx_nsec_i,
  input  logic [ID_W-1:0]   tx_id_i,
  input  logic              rx_evt_i,
  input  logic [PORT_W-1:0] rx_port_i,
  input  logic [NSEC_W-1:0] rx_nsec_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       push_n;
  tsq_entry_t       wr0, wr1, head;
  logic             drop, pop;
  logic [CNT_W-1:0] count;

  tsq_admit #(
    .DEPTH(DEPTH), .PORT_W(PORT_W), .NSEC_W(NSEC_W), .ID_W(ID_W)
  ) u_admit (
    .tx_evt (tx_evt_i),
    .tx_port(tx_port_i),
    .tx_nsec(tx_nsec_i),
    .tx_id  (tx_id_i),
    .rx_evt (rx_evt_i),
    .rx_port(rx_port_i),
    .rx_nsec(rx_nsec_i),
    .count  (count),
    .push_n (push_n),
    .wr0    (wr0),
    .wr1    (wr1),
    .drop   (drop)
  );

  tsq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .push_n(push_n),
    .wr0   (wr0),
    .wr1   (wr1),
    .pop   (pop),
    .head  (head),
    .count (count)
  );

  tsq_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr_i),
    .we      (reg_we_i),
    .wdata   (reg_wdata_i),
    .head    (head),
    .nonempty(count != '0),
    .drop    (drop),
    .rdata   (reg_rdata_o),
    .pop     (pop),
    .irq     (irq_o)
  );

  AST_PAIR_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt_i && (count > CNT_W'(DEPTH - 2)))
      |=> (count == $past(count) - {{(CNT_W-1){1'b0}}, $past(pop)})); // R8

  AST_IRQ_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !irq_o); // R10

endmodule

// File: tb/ts_capture_fifo_tb.sv
module ts_capture_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int PORT_W = 6;
  localparam int NSEC_W = 30;
  localparam int ID_W   = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tx_evt = 1'b0, rx_evt = 1'b0;
  logic [PORT_W-1:0] tx_port = '0, rx_port = '0;
  logic [NSEC_W-1:0] tx_nsec = '0, rx_nsec = '0;
  logic [ID_W-1:0]   tx_id = '0;
  logic [1:0]        addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_capture_fifo #(.DEPTH(DEPTH), .PORT_W(PORT_W), .NSEC_W(NSEC_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_evt_i(tx_evt), .tx_port_i(tx_port), .tx_nsec_i(tx_nsec), .tx_id_i(tx_id),
    .rx_evt_i(rx_evt), .rx_port_i(rx_port), .rx_nsec_i(rx_nsec),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [NSEC_W-1:0] nsec;
    logic [ID_W-1:0]   id;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{port: 6'd0,  nsec: 30'd0,          id: 24'h000000},
    '{port: 6'd63, nsec: 30'h3FFF_FFFF,  id: 24'hFFFFFF},
    '{port: 6'd5,  nsec: 30'd123456789,  id: 24'h0001A5},
    '{port: 6'd17, nsec: 30'd999999999,  id: 24'hABCD00},
    '{port: 6'd42, nsec: 30'h1555_5555,  id: 24'h5A5AFF},
    '{port: 6'd1,  nsec: 30'd1,          id: 24'h000101}
  };

  localparam logic [31:0] POP = 32'h18;  // pop + keep interrupt enable
  localparam logic [31:0] IEN = 32'h10;
  localparam logic [31:0] CLR = 32'h12;  // overflow clear + keep enable

  function automatic logic [31:0] ctl(bit v, bit o, bit t, bit ie, logic [7:0] p);
    return {16'h0, p, 3'b0, ie, 1'b0, t, o, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic tx_ev(input logic [PORT_W-1:0] p, input logic [NSEC_W-1:0] n, input logic [ID_W-1:0] id);
    @(negedge clk);
    tx_evt = 1'b1; tx_port = p; tx_nsec = n; tx_id = id;
    @(negedge clk);
    tx_evt = 1'b0;
  endtask

  task automatic rx_ev(input logic [PORT_W-1:0] p, input logic [NSEC_W-1:0] n);
    @(negedge clk);
    rx_evt = 1'b1; rx_port = p; rx_nsec = n;
    @(negedge clk);
    rx_evt = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_stamp [16];
    bit          exp_tx    [16];

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R12: reset state
    rd(2'd0, d); chk("R12 reset ctrl", d, 32'h0);
    chk("R12 reset irq", {31'b0, irq}, 32'h0);

    // R6: empty reads and ignored pop
    rd(2'd1, d); chk("R6 empty stamp", d, 32'h0);
    rd(2'd2, d); chk("R6 empty subns", d, 32'h0);
    wr(2'd0, POP);
    rd(2'd0, d); chk("R6 pop on empty", d, ctl(0, 0, 0, 1, 8'd0));
    chk("R10 enabled but empty", {31'b0, irq}, 32'h0);

    // R10: interrupt gated by enable
    wr(2'd0, 32'h0);
    rx_ev(6'd9, 30'd1000);
    chk("R10 irq disabled", {31'b0, irq}, 32'h0);
    wr(2'd0, IEN);
    chk("R10 irq enabled", {31'b0, irq}, 32'h1);
    // R3 + R6: the entry landed where the ignored pop left the pointers
    rd(2'd0, d); chk("R3 rx ctrl", d, ctl(1, 0, 0, 1, 8'd9));
    rd(2'd1, d); chk("R3 rx stamp", d, 32'd1000);
    rd(2'd2, d); chk("R3 rx subns", d, 32'h0);
    wr(2'd0, POP);
    chk("R10 irq after drain", {31'b0, irq}, 32'h0);

    // R1 R2 R4 R5: vector table
    foreach (VECS[i]) begin
      tx_ev(VECS[i].port, VECS[i].nsec, VECS[i].id);
      rd(2'd0, d); chk("R1 tx ctrl", d, ctl(1, 0, 1, 1, 8'(VECS[i].port)));
      rd(2'd1, d); chk("R1 tx stamp", d, 32'(VECS[i].nsec));
      wr(2'd0, POP);
      rd(2'd0, d); chk("R1 id ctrl", d, ctl(1, 0, 0, 1, 8'(VECS[i].port)));
      rd(2'd1, d); chk("R2 id stamp", d, 32'(VECS[i].id >> 8));
      rd(2'd2, d); chk("R2 id subns", d, 32'(VECS[i].id[7:0]));
      wr(2'd0, POP);
      rd(2'd0, d); chk("R5 drained", d, ctl(0, 0, 0, 1, 8'd0));
    end

    // R8: fill 7 pairs + 1 rx = 15, then a pair must be dropped whole
    for (int i = 0; i < 7; i++) begin
      tx_ev(6'(i), 30'(100 + i), 24'((i << 8) | i));
      exp_stamp[2*i] = 32'(100 + i); exp_tx[2*i] = 1;
      exp_stamp[2*i+1] = 32'(i);     exp_tx[2*i+1] = 0;
    end
    rx_ev(6'd7, 30'd500); exp_stamp[14] = 32'd500; exp_tx[14] = 0;
    tx_ev(6'd8, 30'd555, 24'h777777);
    rd(2'd0, d); chk("R8 pair dropped", d, ctl(1, 1, 1, 1, 8'd0));
    rx_ev(6'd8, 30'd600); exp_stamp[15] = 32'd600; exp_tx[15] = 0;

    // R7: drop coincident with clear keeps overflow
    @(negedge clk);
    rx_evt = 1'b1; rx_port = 6'd9; rx_nsec = 30'd650;
    addr = 2'd0; we = 1'b1; wdata = CLR;
    @(negedge clk);
    rx_evt = 1'b0; we = 1'b0;
    rd(2'd0, d); chk("R7 set beats clear", d, ctl(1, 1, 1, 1, 8'd0));
    wr(2'd0, CLR);
    rd(2'd0, d); chk("R7 w1c clear", d, ctl(1, 0, 1, 1, 8'd0));

    // R11: push + pop on a full queue, push dropped
    @(negedge clk);
    rx_evt = 1'b1; rx_port = 6'd10; rx_nsec = 30'd660;
    addr = 2'd0; we = 1'b1; wdata = POP;
    @(negedge clk);
    rx_evt = 1'b0; we = 1'b0;
    rd(2'd0, d); chk("R11 full push dropped", d, ctl(1, 1, 0, 1, 8'd0));

    // R4 R8: remaining 15 in arrival order, nothing of the dropped pair
    for (int i = 1; i < 16; i++) begin
      rd(2'd1, d); chk("R4 order stamp", d, exp_stamp[i]);
      rd(2'd0, d); chk("R4 order tx flag", {31'b0, d[2]}, {31'b0, exp_tx[i]});
      wr(2'd0, POP);
    end
    rd(2'd0, d); chk("R8 nothing left", d, ctl(0, 1, 0, 1, 8'd0));
    wr(2'd0, CLR);

    // R11: push + pop at occupancy 1
    rx_ev(6'd11, 30'd700);
    @(negedge clk);
    rx_evt = 1'b1; rx_port = 6'd12; rx_nsec = 30'd800;
    addr = 2'd0; we = 1'b1; wdata = POP;
    @(negedge clk);
    rx_evt = 1'b0; we = 1'b0;
    rd(2'd1, d); chk("R11 new head", d, 32'd800);
    wr(2'd0, POP);
    rd(2'd0, d); chk("R11 count held", d, ctl(0, 0, 0, 1, 8'd0));

    // R9: coincident tx and rx
    @(negedge clk);
    tx_evt = 1'b1; tx_port = 6'd5; tx_nsec = 30'd900; tx_id = 24'h123456;
    rx_evt = 1'b1; rx_port = 6'd6; rx_nsec = 30'd950;
    @(negedge clk);
    tx_evt = 1'b0; rx_evt = 1'b0;
    rd(2'd1, d); chk("R9 tx kept", d, 32'd900);
    wr(2'd0, POP);
    rd(2'd2, d); chk("R9 id subns", d, 32'h56);
    wr(2'd0, POP);
    rd(2'd0, d); chk("R9 rx dropped", d, ctl(0, 1, 0, 1, 8'd0));

    finish_run();
  end

endmodule